// File: doc/BRIEF.md
# Round-Robin Channel Pipeline Scheduler

This block shares one compression core between the three colour channels of a video path. Each of the luminance (Y) and two colour-difference (Cb, Cr) block buffers raises a ready flag when it holds a full block. The scheduler picks one ready channel and grants it the core. For that grant it steers the channel and quantisation-table selects, pulses a read strobe to the chosen buffer and a start strobe to the core. It then waits for the core's done indication before it makes the next grant.

The scheduler rotates through the channels: Y, then Cb, then Cr, then back to Y. After a channel is served, the next search starts at the channel that follows it. A busy channel therefore cannot shut out the others. A global enable stops new grants but lets a block that is already running finish.

Top module: `rr_pipe_sched`

## Requirements
- R1: While reset is high, and in the cycle after it is released, `start_o` is 0, `rd_en` is 000, `chan_sel` is 00 and `tbl_sel` is 00.
- R2: `chan_sel` names the granted channel: 00 for Y, 01 for Cb, 10 for Cr. The value 11 never appears.
- R3: `tbl_sel` is 00 (luminance table) when Y is granted and 01 (chrominance table) when Cb or Cr is granted.
- R4: A grant shows as exactly one cycle with `start_o` high. In that same cycle one bit of `rd_en` is set (bit 0 for Y, bit 1 for Cb, bit 2 for Cr), and `rd_en` is 000 in every other cycle.
- R5: A channel is granted only if its ready bit (`rdy[0]` Y, `rdy[1]` Cb, `rdy[2]` Cr) was high on the clock edge that made the grant. A channel whose ready bit is low is skipped.
- R6: The search for a grant begins at the channel after the one served last, in the cyclic order Y, Cb, Cr. After reset it begins at Y. With all three ready, the grants therefore run Y, Cb, Cr, Y, and so on.
- R7: After a grant, no further `start_o` occurs until `done_i` has been sampled high. `chan_sel` and `tbl_sel` hold their values throughout this wait.
- R8: While `en` is low, no grant is made. A grant already in progress still accepts `done_i`, and it returns the scheduler to idle.
- R9: When `en` is high and a channel is ready, `start_o` rises on the first edge after the scheduler is idle. If `done_i` is sampled high on edge N, the next `start_o` is high after edge N+1 and not after edge N.
- R10: With no ready bit set, the scheduler stays idle and never raises `start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Permits new grants when high |
| rdy | input | 3 | Block-ready flags: bit 0 Y, bit 1 Cb, bit 2 Cr |
| done_i | input | 1 | Shared core has finished the current block |
| chan_sel | output | 2 | Granted channel: 00 Y, 01 Cb, 10 Cr |
| tbl_sel | output | 2 | Quantisation table: 00 luminance, 01 chrominance |
| rd_en | output | 3 | One-cycle read strobe to the granted buffer |
| start_o | output | 1 | One-cycle launch strobe to the shared core |

## Verification
The hardest state to reach from the ports is a rotation pointer that points away from Y while a channel earlier in the order is also ready. Only that state shows that the search really resumes after the last served channel. The bench gets there by first serving only Cb. It then raises all three ready flags and expects Cr, not Y, to win. Later it offers only Y and Cr, so the grant must skip the non-ready Cb. The enable-low case also needs an in-flight block, so the bench drops `en` in the same cycle as the start strobe.

// File: rtl/rr_pipe_sched.sv
module rr_pipe_sched (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] rdy,
  input  logic       done_i,
  output logic [1:0] chan_sel,
  output logic [1:0] tbl_sel,
  output logic [2:0] rd_en,
  output logic       start_o
);

  logic       busy;
  logic [1:0] ptr;
  logic [1:0] c0, c1, c2;
  logic       hit;
  logic [1:0] pick;

  assign c0 = ptr;
  assign c1 = (ptr == 2'd2) ? 2'd0 : ptr + 2'd1;
  assign c2 = (ptr == 2'd0) ? 2'd2 : ptr - 2'd1;

  always_comb begin
    hit  = 1'b1;
    pick = c0;
    if (rdy[c0])      pick = c0;
    else if (rdy[c1]) pick = c1;
    else if (rdy[c2]) pick = c2;
    else              hit  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      ptr      <= 2'd0;
      chan_sel <= 2'b00;
      tbl_sel  <= 2'b00;
      rd_en    <= 3'b000;
      start_o  <= 1'b0;
    end else begin
      start_o <= 1'b0;
      rd_en   <= 3'b000;
      if (busy) begin
        if (done_i) begin
          busy <= 1'b0;
          ptr  <= (chan_sel == 2'd2) ? 2'd0 : chan_sel + 2'd1;
        end
      end else if (en && hit) begin
        busy        <= 1'b1;
        chan_sel    <= pick;
        tbl_sel     <= (pick == 2'd0) ? 2'b00 : 2'b01;
        rd_en[pick] <= 1'b1;
        start_o     <= 1'b1;
      end
    end
  end

  a_r2_legal_chan: assert property (@(posedge clk) disable iff (rst)
    chan_sel != 2'b11);

  a_r3_table_match: assert property (@(posedge clk) disable iff (rst)
    tbl_sel == ((chan_sel == 2'b00) ? 2'b00 : 2'b01));

  a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  a_r4_strobe_with_start: assert property (@(posedge clk) disable iff (rst)
    (rd_en != 3'b000) |-> (start_o && $onehot0(rd_en)));

  a_r5_granted_ready: assert property (@(posedge clk) disable iff (rst)
    start_o |-> (($past(rdy) & rd_en) != 3'b000));

  a_r8_enable_gate: assert property (@(posedge clk) disable iff (rst)
    start_o |-> $past(en));

  a_r7_hold_selects: assert property (@(posedge clk) disable iff (rst)
    (busy && !start_o) |-> ($stable(chan_sel) && $stable(tbl_sel)));

endmodule

// File: tb/rr_pipe_sched_bench.sv
module rr_pipe_sched_bench;
  logic       clk = 1'b0;
  logic       rst, en, done_i;
  logic [2:0] rdy;
  logic [1:0] chan_sel, tbl_sel;
  logic [2:0] rd_en;
  logic       start_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rr_pipe_sched u_rr_pipe_sched (
    .clk(clk), .rst(rst), .en(en), .rdy(rdy), .done_i(done_i),
    .chan_sel(chan_sel), .tbl_sel(tbl_sel), .rd_en(rd_en), .start_o(start_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // waits for a grant, checks it, holds it for a while, then completes it
  task automatic serve(input logic [1:0] ch);
    int waited = 0;
    while (!start_o && waited < 20) begin
      step();
      waited++;
    end
    chk("R9 grant seen", {7'd0, start_o}, 8'd1);
    chk("R2 channel code", {6'd0, chan_sel}, {6'd0, ch});
    chk("R3 table code", {6'd0, tbl_sel}, (ch == 2'd0) ? 8'd0 : 8'd1);
    chk("R4 read strobe", {5'd0, rd_en}, {5'd0, 3'b001 << ch});
    step();
    chk("R4 start one cycle", {7'd0, start_o}, 8'd0);
    chk("R4 strobe one cycle", {5'd0, rd_en}, 8'd0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R7 no restart before done", {7'd0, start_o}, 8'd0);
      chk("R7 channel held", {6'd0, chan_sel}, {6'd0, ch});
    end
    done_i = 1'b1;
    step();
    done_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; en = 1'b1; rdy = 3'b000; done_i = 1'b0;
    step(); step();
    chk("R1 start in reset", {7'd0, start_o}, 8'd0);
    chk("R1 strobe in reset", {5'd0, rd_en}, 8'd0);
    chk("R1 channel in reset", {6'd0, chan_sel}, 8'd0);
    chk("R1 table in reset", {6'd0, tbl_sel}, 8'd0);
    rst = 1'b0;
    step();
    chk("R1 start after release", {7'd0, start_o}, 8'd0);
  endtask

  task automatic t_idle_none();
    rdy = 3'b000;
    for (int i = 0; i < 10; i++) begin
      step();
      chk("R10 no ready no start", {7'd0, start_o}, 8'd0);
    end
  endtask

  task automatic t_single_cb();
    rdy = 3'b010;
    serve(2'd1);
  endtask

  task automatic t_rotation_r6();
    rdy = 3'b111;
    serve(2'd2);
    serve(2'd0);
    serve(2'd1);
    serve(2'd2);
  endtask

  task automatic t_skip_r5();
    rdy = 3'b101;
    serve(2'd0);
    serve(2'd2);
    serve(2'd0);
  endtask

  task automatic t_enable_r8();
    en = 1'b0; rdy = 3'b111;
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R8 no grant while disabled", {7'd0, start_o}, 8'd0);
    end
    en = 1'b1;
    step();
    chk("R8 grant after enable", {7'd0, start_o}, 8'd1);
    chk("R6 resumes at Cb", {6'd0, chan_sel}, 8'd1);
    en = 1'b0;
    step(); step();
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R8 finished, still no grant", {7'd0, start_o}, 8'd0);
    end
    en = 1'b1;
    step();
    chk("R8 in-flight done was accepted", {7'd0, start_o}, 8'd1);
    chk("R6 next after Cb is Cr", {6'd0, chan_sel}, 8'd2);
  endtask

  task automatic t_latency_r9();
    step(); step();
    done_i = 1'b1;
    step();
    done_i = 1'b0;
    chk("R9 no start on done edge", {7'd0, start_o}, 8'd0);
    step();
    chk("R9 start one edge after done", {7'd0, start_o}, 8'd1);
    chk("R6 wraps to Y", {6'd0, chan_sel}, 8'd0);
    chk("R3 Y uses luminance", {6'd0, tbl_sel}, 8'd0);
  endtask

  initial begin
    t_reset();
    t_idle_none();
    t_single_cb();
    t_rotation_r6();
    t_skip_r5();
    t_enable_r8();
    t_latency_r9();
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule